// File: doc/BRIEF.md
# Sequential Child-Task Launcher

This block runs a fixed chain of child state machines one at a time. Each child takes a one-cycle start pulse and gives back a level done signal that is high whenever the child is idle. The launcher has the same start/done interface towards its own requester, so one launcher can act as a child of another and build deeper sequences.

A position register holds the step in progress. Zero means idle. A request moves the position to the first step. The first child is launched at once. Each later child is launched only when the child before it reports done. After the last child is launched, the position goes back to zero. The launcher reports done only when its position is zero and the last child has finished. It does not AND all the child done signals, because every child is done before the chain has run.

Children are expected to drop done in the cycle after their start pulse. The launcher therefore never sees a stale done from a child it has just launched.

Top module: `seq_chain_ctrl`

## Requirements
- R1: After reset the position is idle, no child start is asserted, `done_o` is 1 and `busy_o` is 0, provided every child is reporting done.
- R2: A `go_i` pulse sampled while `done_o` is 1 makes `child_start_o[0]` high in the next cycle, without waiting on any child.
- R3: Within a run, the children start exactly once each, in index order 0 to N-1. Child k (k ≥ 1) starts only in a cycle where child k-1 reports done.
- R4: At most one bit of `child_start_o` is high in any cycle.
- R5: `done_o` is 0 from the cycle after an accepted request until the last child has been launched and reports done again. It is never 1 while the last child is not done.
- R6: A `go_i` pulse sampled while `busy_o` is 1 is ignored and causes no extra child start.
- R7: `busy_o` is always the inverse of `done_o`.
- R8: When a child is launched, every child reports done. A child that drops done for a single cycle still holds back the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | One-cycle request to run the chain |
| child_done_i | input | N_CHILD | Level done from each child, bit k for child k |
| child_start_o | output | N_CHILD | One-cycle start pulse to each child |
| busy_o | output | 1 | Chain running or last child still working |
| done_o | output | 1 | Idle with last child finished |

## Verification
The hardest case to reach from the ports is a child whose done is low for only one cycle. In that case a launcher that wrongly trusts the level it sees right after its own launch would start the next child too early. The bench uses behavioural children with a configurable random latency and runs whole chains with latency zero, so that this one-cycle window occurs at every step. At every launch it checks that all children are done. Other runs use longer latencies and scatter request pulses through the busy period, including the tail where the position is already idle but the last child is still working.

// File: rtl/seq_chain_pkg.sv
package seq_chain_pkg;
  // bits needed to hold positions 0..n
  function automatic int pos_bits(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/seq_pos_reg.sv
module seq_pos_reg #(
  parameter int N_CHILD = 4,
  parameter int PW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          step_i,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] LAST = PW'(N_CHILD);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (pos_q == '0) begin
      if (accept_i) pos_q <= PW'(1);
    end else if (step_i) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
    end
  end

  assign pos_o = pos_q;

  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (accept_i && pos_q == '0) |=> (pos_q == PW'(1))); // R2
  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (rst)
    (pos_q != '0 && !step_i) |=> $stable(pos_q)); // R3
  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pos_q == LAST && step_i) |=> (pos_q == '0)); // R5
endmodule

// File: rtl/seq_launch_dec.sv
module seq_launch_dec #(
  parameter int N_CHILD = 4,
  parameter int PW      = 3
) (
  input  logic [PW-1:0]      pos_i,
  input  logic [N_CHILD-1:0] child_done_i,
  output logic [N_CHILD-1:0] launch_o,
  output logic               step_o,
  output logic               idle_done_o
);
  for (genvar k = 0; k < N_CHILD; k++) begin : g_slot
    if (k == 0) begin : g_first
      assign launch_o[k] = (pos_i == PW'(1));
    end else begin : g_next
      assign launch_o[k] = (pos_i == PW'(k + 1)) && child_done_i[k-1];
    end
  end

  assign step_o      = |launch_o;
  assign idle_done_o = (pos_i == '0) && child_done_i[N_CHILD-1];
endmodule

// File: rtl/seq_chain_ctrl.sv
module seq_chain_ctrl #(
  parameter int N_CHILD = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [N_CHILD-1:0] child_done_i,
  output logic [N_CHILD-1:0] child_start_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int PW = seq_chain_pkg::pos_bits(N_CHILD);

  logic [PW-1:0] pos;
  logic          step;
  logic          idle_done;
  logic          accept;

  assign accept = go_i && idle_done;

  seq_pos_reg #(.N_CHILD(N_CHILD), .PW(PW)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .step_i   (step),
    .pos_o    (pos)
  );

  seq_launch_dec #(.N_CHILD(N_CHILD), .PW(PW)) u_dec (
    .pos_i        (pos),
    .child_done_i (child_done_i),
    .launch_o     (child_start_o),
    .step_o       (step),
    .idle_done_o  (idle_done)
  );

  assign done_o = idle_done;
  assign busy_o = !idle_done;

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(child_start_o)); // R4
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (go_i && busy_o) |=> !child_start_o[0]); // R6
  AST_GO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (go_i && done_o) |=> child_start_o[0]); // R2
endmodule

// File: tb/tb_seq_chain_ctrl.sv
module tb_child (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  int   max_lat,
  output logic done
);
  int cnt;
  always @(posedge clk) begin
    if (rst) begin
      done <= 1'b1;
      cnt  <= 0;
    end else if (start) begin
      done <= 1'b0;
      cnt  <= $urandom_range(max_lat, 0);
    end else if (!done) begin
      if (cnt == 0) done <= 1'b1;
      else          cnt  <= cnt - 1;
    end
  end
endmodule

module tb_seq_chain_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go  = 1'b0;
  logic [N-1:0] cdone;
  logic [N-1:0] cstart;
  logic         busy;
  logic         done;
  int           max_lat = 0;
  int           vec = 0;
  int           miss = 0;
  int           q[$];

  always #2 clk = ~clk;

  seq_chain_ctrl #(.N_CHILD(N)) dut (
    .clk           (clk),
    .rst           (rst),
    .go_i          (go),
    .child_done_i  (cdone),
    .child_start_o (cstart),
    .busy_o        (busy),
    .done_o        (done)
  );

  for (genvar k = 0; k < N; k++) begin : g_child
    tb_child u_c (
      .clk     (clk),
      .rst     (rst),
      .start   (cstart[k]),
      .max_lat (max_lat),
      .done    (cdone[k])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected launch order
  always @(negedge clk) begin
    if (!rst) begin
      chk($onehot0(cstart), "R4", int'(cstart), 0);
      chk(busy == !done, "R7", int'(busy), int'(!done));
      if (done) chk(cdone[N-1], "R5", int'(cdone[N-1]), 1);
      for (int k = 0; k < N; k++) begin
        if (cstart[k]) begin
          if (q.size() == 0) begin
            chk(1'b0, "R6 unexpected launch", k, -1);
          end else begin
            int e;
            e = q.pop_front();
            chk(k == e, "R3 order", k, e);
          end
          chk(&cdone, "R8 all children done at launch", int'(cdone), (1 << N) - 1);
        end
      end
    end
  end

  task automatic run_job(input int lat, input bit extra_go);
    max_lat = lat;
    for (int k = 0; k < N; k++) q.push_back(k);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(cstart[0], "R2 first launch", int'(cstart[0]), 1);
    chk(!done, "R5 done low after accept", int'(done), 0);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) break;
      go = (extra_go && $urandom_range(2, 0) == 0);
    end
    go = 1'b0;
    chk(done, "R5 done returns", int'(done), 1);
    chk(q.size() == 0, "R3 all children launched", q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cstart == '0, "R1 no start after reset", int'(cstart), 0);
    chk(done, "R1 done after reset", int'(done), 1);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    // R6: idle cycles without go launch nothing
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R6 idle", q.size(), 0);

    run_job(0, 1'b0);   // R8 one-cycle done drops
    run_job(0, 1'b1);
    run_job(5, 1'b1);   // R6 go pulses while busy
    run_job(2, 1'b0);
    for (int j = 0; j < 12; j++) run_job(j % 7, j[0]);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 final queue", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule